// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address for a processor front end. A table of entries is read with the current fetch PC. Each entry holds four things: a valid bit, the upper bits of the branch address as a tag, the last resolved branch target, and a 2-bit saturating up/down counter that predicts the branch direction. The lookup is combinational. When the table hits and the counter predicts taken, the block returns the stored target as the next PC. In every other case it returns PC+4. The block never stores a fall-through address.

When a branch resolves, the back end presents its address, its outcome and its target on an update port. If the branch hits in the table, the block trains its counter and refreshes its target. If a taken branch misses, the block allocates an entry for it. In the same cycle, the block reports whether the earlier prediction for that branch was right. A flush input clears every entry, and the core raises it on a context switch.

Top module: `btb_predictor`

## Requirements
- R1: The table is direct-mapped with 64 entries. The index is PC bits [7:2]. The tag is PC bits [31:8]. Lookup hits only when the indexed entry is valid and its tag matches, so PC bits [1:0] play no part.
- R2: After reset, no lookup hits. `lk_taken` is 0 and `lk_next_pc` equals `lk_pc + 4`.
- R3: A lookup predicts taken only on a hit whose counter is 2 or 3. In that case `lk_next_pc` equals the stored target. On a miss, or on a counter of 0 or 1, `lk_next_pc` is `lk_pc + 4`.
- R4: A taken update that misses allocates the entry. It writes the tag and the resolved target, and it sets the counter to 2. The new entry is visible to lookups from the next cycle.
- R5: A not-taken update that misses changes nothing. A later lookup of that address still misses, and the entry it maps to keeps its contents.
- R6: An update that hits moves the counter up by one on taken and down by one on not-taken. The counter saturates at 3 and at 0.
- R7: A taken update that hits with a different target overwrites the stored target.
- R8: An update to an address whose index holds another tag replaces that entry. The displaced branch then misses.
- R9: `up_correct` is 1 in either of two cases. In the first, the update hits, the predicted direction equals `up_taken`, and, when taken, the stored target equals `up_target`. In the second, the update misses and the branch is not taken.
- R10: A pulse on `flush` invalidates every entry, so all lookups miss from the next cycle. An update in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_pc | input | 32 | Fetch PC for lookup |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_taken | output | 1 | Lookup predicts a taken branch |
| lk_target | output | 32 | Stored target of the hit entry (0 on miss) |
| lk_next_pc | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved target address |
| up_correct | output | 1 | The earlier prediction for this branch was correct |

## Verification
The hardest states to reach are the counter saturation limits. A wrapping counter and a clamping counter look the same at the lookup port until the counter is pushed past an end and then stepped back. The bench therefore drives long runs of identical outcomes into one entry. It then reverses direction and watches the exact step where the prediction flips. Aliasing and the flush-versus-update collision are reached with addresses that share an index, and by raising both inputs in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CTR_W    = 2;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = 2'd2;

  // saturating step of the direction counter
  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c,
                                                input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 1'b1;
    else       return (c == '0)      ? c : c - 1'b1;
  endfunction

  // direction decision from the counter's upper bit
  function automatic logic ctr_pred(input logic [CTR_W-1:0] c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/btb_entry.sv
module btb_entry #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      we,
  input  logic [TAG_W-1:0]          wtag,
  input  logic [PC_W-1:0]           wtgt,
  input  logic [btb_pkg::CTR_W-1:0] wcnt,
  output logic                      valid,
  output logic [TAG_W-1:0]          tag,
  output logic [PC_W-1:0]           tgt,
  output logic [btb_pkg::CTR_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      tgt   <= '0;
      cnt   <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (we) begin
      valid <= 1'b1;
      tag   <= wtag;
      tgt   <= wtgt;
      cnt   <= wcnt;
    end
  end
endmodule

// File: rtl/btb_read.sv
module btb_read #(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int PC_W  = 32,
  parameter int TAG_W = 24
) (
  input  logic                      valid_v [N],
  input  logic [TAG_W-1:0]          tag_a   [N],
  input  logic [PC_W-1:0]           tgt_a   [N],
  input  logic [btb_pkg::CTR_W-1:0] cnt_a   [N],
  input  logic [IDX_W-1:0]          idx,
  input  logic [TAG_W-1:0]          tag,
  output logic                      hit,
  output logic [PC_W-1:0]           tgt,
  output logic [btb_pkg::CTR_W-1:0] cnt
);
  always_comb begin
    hit = valid_v[idx] && (tag_a[idx] == tag);
    tgt = tgt_a[idx];
    cnt = cnt_a[idx];
  end
endmodule

// File: rtl/btb_update.sv
module btb_update #(
  parameter int PC_W = 32
) (
  input  logic                      up_valid,
  input  logic                      flush,
  input  logic                      hit,
  input  logic                      taken,
  input  logic [PC_W-1:0]           old_tgt,
  input  logic [btb_pkg::CTR_W-1:0] old_cnt,
  input  logic [PC_W-1:0]           res_tgt,
  output logic                      wr,
  output logic [PC_W-1:0]           new_tgt,
  output logic [btb_pkg::CTR_W-1:0] new_cnt,
  output logic                      correct
);
  import btb_pkg::*;
  logic pred_t;
  always_comb begin
    pred_t  = hit && ctr_pred(old_cnt);
    wr      = up_valid && !flush && (hit || taken);
    new_tgt = taken ? res_tgt : old_tgt;
    new_cnt = hit ? ctr_step(old_cnt, taken) : CTR_INIT;
    if (hit) correct = (pred_t == taken) && (!taken || (old_tgt == res_tgt));
    else     correct = !taken;
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  output logic            up_correct
);
  import btb_pkg::*;
  localparam int N     = 1 << IDX_W;
  localparam int LSB   = 2;
  localparam int TAG_W = PC_W - IDX_W - LSB;

  logic             e_valid [N];
  logic [TAG_W-1:0] e_tag   [N];
  logic [PC_W-1:0]  e_tgt   [N];
  logic [CTR_W-1:0] e_cnt   [N];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_idx = lk_pc[LSB +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_idx = up_pc[LSB +: IDX_W];
  assign up_tag = up_pc[PC_W-1 -: TAG_W];

  // named internal events for the checker
  logic             u_hit, u_wr;
  logic [PC_W-1:0]  u_tgt_old, u_tgt_new;
  logic [CTR_W-1:0] u_cnt_old, u_cnt_new;
  logic             l_hit;
  logic [PC_W-1:0]  l_tgt;
  logic [CTR_W-1:0] l_cnt;

  btb_read #(.N(N), .IDX_W(IDX_W), .PC_W(PC_W), .TAG_W(TAG_W)) u_rd_lk (
    .valid_v(e_valid), .tag_a(e_tag), .tgt_a(e_tgt), .cnt_a(e_cnt),
    .idx(lk_idx), .tag(lk_tag), .hit(l_hit), .tgt(l_tgt), .cnt(l_cnt));

  btb_read #(.N(N), .IDX_W(IDX_W), .PC_W(PC_W), .TAG_W(TAG_W)) u_rd_up (
    .valid_v(e_valid), .tag_a(e_tag), .tgt_a(e_tgt), .cnt_a(e_cnt),
    .idx(up_idx), .tag(up_tag), .hit(u_hit), .tgt(u_tgt_old), .cnt(u_cnt_old));

  btb_update #(.PC_W(PC_W)) u_upd (
    .up_valid(up_valid), .flush(flush), .hit(u_hit), .taken(up_taken),
    .old_tgt(u_tgt_old), .old_cnt(u_cnt_old), .res_tgt(up_target),
    .wr(u_wr), .new_tgt(u_tgt_new), .new_cnt(u_cnt_new), .correct(up_correct));

  for (genvar i = 0; i < N; i++) begin : g_ent
    btb_entry #(.PC_W(PC_W), .TAG_W(TAG_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .we(u_wr && (up_idx == IDX_W'(i))),
      .wtag(up_tag), .wtgt(u_tgt_new), .wcnt(u_cnt_new),
      .valid(e_valid[i]), .tag(e_tag[i]), .tgt(e_tgt[i]), .cnt(e_cnt[i]));
  end

  always_comb begin
    lk_hit     = l_hit;
    lk_taken   = l_hit && ctr_pred(l_cnt);
    lk_target  = l_hit ? l_tgt : '0;
    lk_next_pc = lk_taken ? l_tgt : lk_pc + PC_W'(4);
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_hit,
  input logic            lk_taken,
  input logic [PC_W-1:0] lk_target,
  input logic [PC_W-1:0] lk_next_pc,
  input logic            up_valid,
  input logic            up_taken,
  input logic            u_hit,
  input logic            u_wr,
  input logic [1:0]      u_cnt_old,
  input logic [1:0]      u_cnt_new
);
  // R3
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);
  // R3
  seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_taken |-> (lk_next_pc == lk_pc + PC_W'(4)));
  // R3
  redirect_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> (lk_next_pc == lk_target));
  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);
  // R5
  nt_miss_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !u_hit && !up_taken) |-> !u_wr);
  // R4
  alloc_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !flush && !u_hit && up_taken) |-> (u_wr && u_cnt_new == 2'd2));
  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_wr && u_hit && up_taken && u_cnt_old == 2'd3) |-> (u_cnt_new == 2'd3));
  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_wr && u_hit && !up_taken && u_cnt_old == 2'd0) |-> (u_cnt_new == 2'd0));
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_pc(lk_pc), .lk_hit(lk_hit),
  .lk_taken(lk_taken), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
  .up_valid(up_valid), .up_taken(up_taken), .u_hit(u_hit), .u_wr(u_wr),
  .u_cnt_old(u_cnt_old), .u_cnt_new(u_cnt_new));

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  logic        clk = 0, rst_n = 0, flush = 0;
  logic [31:0] lk_pc = 0;
  logic        lk_hit, lk_taken, up_correct;
  logic [31:0] lk_target, lk_next_pc;
  logic        up_valid = 0, up_taken = 0;
  logic [31:0] up_pc = 0, up_target = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  btb_predictor dut (.clk(clk), .rst_n(rst_n), .flush(flush), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_target(up_target), .up_correct(up_correct));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // combinational lookup, sampled between edges
  task automatic look(input logic [31:0] pc, input bit e_hit, input bit e_tk,
                      input logic [31:0] e_tgt, input string req);
    @(negedge clk);
    lk_pc = pc;
    #1;
    chk(lk_hit == e_hit, {req, " hit"}, 32'(lk_hit), 32'(e_hit));
    chk(lk_next_pc == (e_tk ? e_tgt : pc + 4), {req, " next"}, lk_next_pc,
        e_tk ? e_tgt : pc + 4);
  endtask

  task automatic upd(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = tk; up_target = tgt;
    @(posedge clk); #1;
    up_valid = 0;
  endtask

  task automatic upd_corr(input logic [31:0] pc, input bit tk,
                          input logic [31:0] tgt, input bit e_c);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = tk; up_target = tgt;
    #1;
    chk(up_correct == e_c, "R9 up_correct", 32'(up_correct), 32'(e_c));
    @(posedge clk); #1;
    up_valid = 0;
  endtask

  task automatic t_reset();
    look(32'h100, 0, 0, 0, "R2 reset");
    look(32'h20FC, 0, 0, 0, "R2 reset");
  endtask

  task automatic t_alloc();
    upd(32'h1000, 1, 32'h2000);
    look(32'h1000, 1, 1, 32'h2000, "R4 alloc");
    look(32'h1003, 1, 1, 32'h2000, "R1 low bits ignored");
  endtask

  task automatic t_nt_miss();
    upd(32'h3004, 0, 32'h4000);
    look(32'h3004, 0, 0, 0, "R5 not allocated");
    upd(32'h1000, 0, 32'h9999);  // index 0 hit: trains, no target change on NT
    look(32'h1000, 1, 0, 0, "R3 counter 1 predicts NT");
    upd(32'h1000, 1, 32'h2000);  // back to 2
  endtask

  task automatic t_counter();
    // push to 3 and beyond, then one NT must still predict taken
    for (int k = 0; k < 4; k++) upd(32'h1000, 1, 32'h2000);
    upd(32'h1000, 0, 32'h2000);
    look(32'h1000, 1, 1, 32'h2000, "R6 clamp at 3");
    upd(32'h1000, 0, 32'h2000);
    look(32'h1000, 1, 0, 0, "R6 step down to 1");
    for (int k = 0; k < 3; k++) upd(32'h1000, 0, 32'h2000);
    upd(32'h1000, 1, 32'h2000);
    look(32'h1000, 1, 0, 0, "R6 clamp at 0");
    upd(32'h1000, 1, 32'h2000);
    look(32'h1000, 1, 1, 32'h2000, "R6 step up to 2");
  endtask

  task automatic t_target();
    upd(32'h1000, 1, 32'h2400);
    look(32'h1000, 1, 1, 32'h2400, "R7 target overwrite");
  endtask

  task automatic t_alias();
    look(32'h1100, 0, 0, 0, "R8 alias miss");
    upd(32'h1100, 1, 32'h5000);
    look(32'h1100, 1, 1, 32'h5000, "R8 new owner");
    look(32'h1000, 0, 0, 0, "R8 displaced");
  endtask

  task automatic t_correct();
    // entry 0x1100: counter 3 after this taken update, target 0x5000
    upd_corr(32'h1100, 1, 32'h5000, 1);
    upd_corr(32'h1100, 1, 32'h5004, 0);  // target changed
    upd_corr(32'h1100, 0, 32'h5004, 0);  // wrong direction (counter 3)
    upd_corr(32'h7008, 0, 32'h0, 1);     // miss, not taken
    upd_corr(32'h7008, 1, 32'h8000, 0);  // miss, taken
  endtask

  task automatic t_flush();
    upd(32'h2004, 1, 32'hA000);
    upd(32'h20FC, 1, 32'hB000);
    look(32'h20FC, 1, 1, 32'hB000, "R10 before flush");
    @(negedge clk);
    flush = 1; up_valid = 1; up_pc = 32'h30F8; up_taken = 1; up_target = 32'hC000;
    @(posedge clk); #1;
    flush = 0; up_valid = 0;
    look(32'h2004, 0, 0, 0, "R10 flushed");
    look(32'h20FC, 0, 0, 0, "R10 flushed");
    look(32'h1100, 0, 0, 0, "R10 flushed");
    look(32'h30F8, 0, 0, 0, "R10 update dropped");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_alloc();
    t_nt_miss();
    t_counter();
    t_target();
    t_alias();
    t_correct();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule